// File: doc/BRIEF.md
# Bulk IN Endpoint Transmit Queue

This block sits between the processor and the USB serial engine of a device controller and holds the data waiting to go out on one bulk IN endpoint. It has two packet buffers of 64 bytes each. The processor fills one buffer while the USB side drains the other, and the two buffers swap roles each time. A buffer becomes a complete packet in one of two ways: its 64th byte is loaded, or the processor strobes `wr_short`, which closes the buffer at whatever byte count it has reached, including zero.

The USB side reads one complete packet per IN transaction, oldest first and byte by byte. `tx_svc` tells the processor whether there is room to stage another packet: it is high while at most one complete packet is held. `flush` discards everything at once.

Both byte interfaces use valid/ready. On the write port a byte moves when `wr_valid` and `wr_ready` are both high. `wr_ready` goes low only while both buffers hold complete packets. A byte offered while it is low is not held waiting; it is discarded and flagged on `ovf_err`. On the read port the block raises `rd_valid` for the head byte of the oldest complete packet. It holds that byte and its flags steady until the reader accepts it with `rd_ready`.

Top module: `bulk_in_txq`

## Requirements
- R1: `tx_svc` is 1 while `pkt_cnt` (the number of complete packets held, 0 to 2) is 0 or 1, and 0 while it is 2. `wr_ready` is 0 exactly when `pkt_cnt` is 2.
- R2: The 64th byte accepted into a buffer completes that packet. The next accepted byte starts the other buffer.
- R3: A `wr_short` strobe completes the current buffer at its present byte count. A byte accepted in the same cycle counts as part of that packet. A strobe with no bytes loaded makes a zero-length packet. The reader sees that packet as a single beat with `rd_valid`, `rd_last` and `rd_empty` all 1. A strobe that arrives together with a 64th byte creates no extra packet.
- R4: While `wr_ready` is 0, offered bytes and `wr_short` strobes change nothing. The cycle after each one, `ovf_err` is 1. When nothing is offered, `ovf_err` is 0 in the following cycle.
- R5: `rd_valid` is 1 only while the oldest buffer holds a complete packet. Its bytes come out in load order, and `rd_last` marks the final byte.
- R6: Accepting the last beat of a packet frees its buffer, and `pkt_cnt` falls by one at that same clock edge. Packets leave in the order they were completed.
- R7: After a clock edge with `flush` high, `pkt_cnt` is 0, `tx_svc` is 1 and `rd_valid` is 0. Partly loaded bytes are discarded, and the next load starts a fresh packet.
- R8: After reset, `pkt_cnt` is 0, `tx_svc` is 1, `wr_ready` is 1, `rd_valid` is 0 and `ovf_err` is 0.
- R9: While `rd_valid` is 1 and `rd_ready` is 0, `rd_valid` stays 1 and `rd_data` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Empties both buffers at the next edge |
| wr_valid | input | 1 | Processor offers a byte |
| wr_ready | output | 1 | A buffer is free to take bytes |
| wr_data | input | 8 | Byte offered by the processor |
| wr_short | input | 1 | Closes the current packet at its present length |
| rd_valid | output | 1 | Head byte of the oldest complete packet is available |
| rd_ready | input | 1 | USB side accepts the head byte |
| rd_data | output | 8 | Head byte |
| rd_last | output | 1 | Head byte is the last one of its packet |
| rd_empty | output | 1 | Head beat belongs to a zero-length packet and carries no byte |
| tx_svc | output | 1 | Room to stage another packet |
| pkt_cnt | output | 2 | Number of complete packets held |
| ovf_err | output | 1 | One-cycle flag for a write or strobe refused while full |

## Verification
Every output except `ovf_err` is combinational logic on registered state, so the effect of a handshake or strobe shows on the ports one edge later. `ovf_err` is a register fed from the refused offer, so it also shows one edge later. The bench changes inputs at the falling edge, lets one rising edge pass, and reads results at the next falling edge. While draining, each byte is checked at the falling edge before the rising edge that accepts it. `pkt_cnt` is then read at the falling edge after the last accepting edge, which confirms the drop happens at that edge.

// File: rtl/txq_pkg.sv
package txq_pkg;
  localparam int unsigned TXQ_DATA_W    = 8;
  localparam int unsigned TXQ_PKT_BYTES = 64;
  localparam int unsigned TXQ_NSLOT     = 2;

  typedef logic slot_sel_t;

  function automatic slot_sel_t other_slot(input slot_sel_t s);
    return ~s;
  endfunction
endpackage

// File: rtl/txq_slot.sv
module txq_slot #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned IDX_W  = $clog2(DEPTH),
  parameter int unsigned LEN_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_byte,
  input  logic              close_en,
  input  logic [LEN_W-1:0]  close_len,
  input  logic              rel_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_byte,
  output logic              full,
  output logic [LEN_W-1:0]  len
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_byte;
  end

  assign rd_byte = mem[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      len  <= '0;
    end else if (flush) begin
      full <= 1'b0;
      len  <= '0;
    end else if (close_en) begin
      full <= 1'b1;
      len  <= close_len;
    end else if (rel_en) begin
      full <= 1'b0;
    end
  end

  // R2: a buffer is only closed while it is free
  p_close_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
    close_en |-> !full);
  // R6: only a held packet is released
  p_release_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rel_en |-> full);
endmodule

// File: rtl/txq_fill_ctl.sv
module txq_fill_ctl
  import txq_pkg::*;
#(
  parameter int unsigned PKT_BYTES = 64,
  parameter int unsigned NSLOT     = 2,
  parameter int unsigned IDX_W     = $clog2(PKT_BYTES),
  parameter int unsigned LEN_W     = $clog2(PKT_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             wr_valid,
  input  logic             wr_short,
  input  logic [NSLOT-1:0] slot_full,
  output logic             wr_ready,
  output logic [NSLOT-1:0] beat_we,
  output logic [NSLOT-1:0] close_mask,
  output logic [IDX_W-1:0] wr_idx,
  output logic [LEN_W-1:0] close_len,
  output logic             ovf_err
);
  localparam logic [LEN_W-1:0] LAST_POS = LEN_W'(PKT_BYTES - 1);

  slot_sel_t        sel;
  logic [LEN_W-1:0] fill;
  logic             beat;
  logic             shut;

  assign wr_ready  = !slot_full[sel];
  assign beat      = wr_valid && wr_ready && !flush;
  assign shut      = wr_ready && !flush && (wr_short || (beat && fill == LAST_POS));
  assign wr_idx    = fill[IDX_W-1:0];
  assign close_len = fill + LEN_W'(beat);

  always_comb begin
    for (int i = 0; i < NSLOT; i++) begin
      beat_we[i]    = beat && (sel == slot_sel_t'(i));
      close_mask[i] = shut && (sel == slot_sel_t'(i));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel     <= 1'b0;
      fill    <= '0;
      ovf_err <= 1'b0;
    end else if (flush) begin
      sel     <= 1'b0;
      fill    <= '0;
      ovf_err <= 1'b0;
    end else begin
      ovf_err <= (wr_valid || wr_short) && !wr_ready;
      if (shut) begin
        fill <= '0;
        sel  <= other_slot(sel);
      end else if (beat) begin
        fill <= fill + LEN_W'(1);
      end
    end
  end

  // R2: the fill count never runs past the last byte position
  p_fill_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= LAST_POS);
  // R4: a refused offer is flagged on the next cycle
  p_ovf_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready && !flush) |=> ovf_err);
  // R4: no offer, no flag
  p_ovf_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_valid && !wr_short) |=> !ovf_err);
endmodule

// File: rtl/txq_drain_ctl.sv
module txq_drain_ctl
  import txq_pkg::*;
#(
  parameter int unsigned PKT_BYTES = 64,
  parameter int unsigned NSLOT     = 2,
  parameter int unsigned IDX_W     = $clog2(PKT_BYTES),
  parameter int unsigned LEN_W     = $clog2(PKT_BYTES + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       rd_ready,
  input  logic [NSLOT-1:0]           slot_full,
  input  logic [NSLOT-1:0][LEN_W-1:0] slot_len,
  output slot_sel_t                  rd_sel,
  output logic [IDX_W-1:0]           rd_idx,
  output logic                       rd_valid,
  output logic                       rd_last,
  output logic                       rd_empty,
  output logic [NSLOT-1:0]           rel_mask
);
  logic [LEN_W-1:0] idx;
  logic [LEN_W-1:0] cur_len;
  logic             fire;

  assign cur_len  = slot_len[rd_sel];
  assign rd_valid = slot_full[rd_sel];
  assign rd_empty = rd_valid && (cur_len == '0);
  assign rd_last  = rd_valid && ((cur_len == '0) || (idx == cur_len - LEN_W'(1)));
  assign rd_idx   = idx[IDX_W-1:0];
  assign fire     = rd_valid && rd_ready && !flush;

  always_comb begin
    for (int i = 0; i < NSLOT; i++)
      rel_mask[i] = fire && rd_last && (rd_sel == slot_sel_t'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_sel <= 1'b0;
      idx    <= '0;
    end else if (flush) begin
      rd_sel <= 1'b0;
      idx    <= '0;
    end else if (fire) begin
      if (rd_last) begin
        idx    <= '0;
        rd_sel <= other_slot(rd_sel);
      end else begin
        idx <= idx + LEN_W'(1);
      end
    end
  end

  // R5: the read position stays inside the packet being sent
  p_idx_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && cur_len != '0) |-> (idx < cur_len));
endmodule

// File: rtl/bulk_in_txq.sv
module bulk_in_txq
  import txq_pkg::*;
#(
  parameter int unsigned DATA_W    = TXQ_DATA_W,
  parameter int unsigned PKT_BYTES = TXQ_PKT_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_short,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_last,
  output logic              rd_empty,
  output logic              tx_svc,
  output logic [1:0]        pkt_cnt,
  output logic              ovf_err
);
  localparam int unsigned NSLOT = TXQ_NSLOT;
  localparam int unsigned IDX_W = $clog2(PKT_BYTES);
  localparam int unsigned LEN_W = $clog2(PKT_BYTES + 1);

  logic [NSLOT-1:0]             slot_full;
  logic [NSLOT-1:0][LEN_W-1:0]  slot_len;
  logic [NSLOT-1:0][DATA_W-1:0] slot_rdata;
  logic [NSLOT-1:0]             beat_we;
  logic [NSLOT-1:0]             close_mask;
  logic [NSLOT-1:0]             rel_mask;
  logic [IDX_W-1:0]             wr_idx;
  logic [IDX_W-1:0]             rd_idx;
  logic [LEN_W-1:0]             close_len;
  slot_sel_t                    rd_sel;

  txq_fill_ctl #(
    .PKT_BYTES(PKT_BYTES), .NSLOT(NSLOT), .IDX_W(IDX_W), .LEN_W(LEN_W)
  ) u_fill (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .wr_valid(wr_valid), .wr_short(wr_short), .slot_full(slot_full),
    .wr_ready(wr_ready), .beat_we(beat_we), .close_mask(close_mask),
    .wr_idx(wr_idx), .close_len(close_len), .ovf_err(ovf_err)
  );

  txq_drain_ctl #(
    .PKT_BYTES(PKT_BYTES), .NSLOT(NSLOT), .IDX_W(IDX_W), .LEN_W(LEN_W)
  ) u_drain (
    .clk(clk), .rst_n(rst_n), .flush(flush), .rd_ready(rd_ready),
    .slot_full(slot_full), .slot_len(slot_len),
    .rd_sel(rd_sel), .rd_idx(rd_idx), .rd_valid(rd_valid),
    .rd_last(rd_last), .rd_empty(rd_empty), .rel_mask(rel_mask)
  );

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    txq_slot #(
      .DATA_W(DATA_W), .DEPTH(PKT_BYTES), .IDX_W(IDX_W), .LEN_W(LEN_W)
    ) u_slot (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .wr_en(beat_we[g]), .wr_idx(wr_idx), .wr_byte(wr_data),
      .close_en(close_mask[g]), .close_len(close_len),
      .rel_en(rel_mask[g]), .rd_idx(rd_idx),
      .rd_byte(slot_rdata[g]), .full(slot_full[g]), .len(slot_len[g])
    );
  end

  always_comb begin
    pkt_cnt = '0;
    for (int i = 0; i < NSLOT; i++) pkt_cnt = pkt_cnt + 2'(slot_full[i]);
  end

  assign tx_svc  = (pkt_cnt < 2'd2);
  assign rd_data = slot_rdata[rd_sel];

  // R1: with both packets held the writer is stopped and service is off
  p_full_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_cnt == 2'd2) |-> (!tx_svc && !wr_ready));
  // R6: a finished packet lowers the count at the accepting edge
  p_cnt_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && rd_last && !flush && close_mask == '0)
      |=> (pkt_cnt == $past(pkt_cnt) - 2'd1));
  // R7: flush empties the queue
  p_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (pkt_cnt == 2'd0 && tx_svc && !rd_valid));
  // R9: a stalled head beat is held steady
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !flush) |=> (rd_valid && $stable(rd_data)));
endmodule

// File: tb/sim_bulk_in_txq.sv
module sim_bulk_in_txq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       flush = 1'b0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [7:0] wr_data = 8'd0;
  logic       wr_short = 1'b0;
  logic       rd_valid;
  logic       rd_ready = 1'b0;
  logic [7:0] rd_data;
  logic       rd_last;
  logic       rd_empty;
  logic       tx_svc;
  logic [1:0] pkt_cnt;
  logic       ovf_err;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  bulk_in_txq u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data), .wr_short(wr_short),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .rd_last(rd_last), .rd_empty(rd_empty),
    .tx_svc(tx_svc), .pkt_cnt(pkt_cnt), .ovf_err(ovf_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push(input int n, input int seed, input bit short_last);
    for (int i = 0; i < n; i++) begin
      wr_valid = 1'b1;
      wr_data  = 8'(seed + i);
      wr_short = short_last && (i == n - 1);
      @(negedge clk);
    end
    wr_valid = 1'b0;
    wr_short = 1'b0;
  endtask

  task automatic strobe_short();
    wr_short = 1'b1;
    @(negedge clk);
    wr_short = 1'b0;
  endtask

  task automatic drain(input int n, input int seed, input int stall, input string req);
    int errs = 0;
    int fa = 0;
    int fe = 0;
    rd_ready = 1'b0;
    for (int s = 0; s < stall; s++) begin
      // R9: head beat held while stalled
      chk(rd_valid && rd_data == 8'(seed), "R9", "stalled head", int'(rd_data), seed & 255);
      @(negedge clk);
    end
    rd_ready = 1'b1;
    if (n == 0) begin
      chk(rd_valid && rd_last && rd_empty, req, "zero-length beat",
          int'({rd_valid, rd_last, rd_empty}), 7);
      @(negedge clk);
    end else begin
      for (int i = 0; i < n; i++) begin
        if (!rd_valid || rd_data != 8'(seed + i) || rd_last != (i == n - 1) || rd_empty) begin
          if (errs == 0) begin fa = int'(rd_data); fe = (seed + i) & 255; end
          errs++;
        end
        @(negedge clk);
      end
    end
    rd_ready = 1'b0;
    chk(errs == 0, req, "packet bytes and last flag", fa, fe);
  endtask

  task automatic t_reset();
    chk(pkt_cnt == 0, "R8", "reset pkt_cnt", pkt_cnt, 0);
    chk(tx_svc, "R8", "reset tx_svc", tx_svc, 1);
    chk(wr_ready, "R8", "reset wr_ready", wr_ready, 1);
    chk(!rd_valid, "R8", "reset rd_valid", rd_valid, 0);
    chk(!ovf_err, "R8", "reset ovf_err", ovf_err, 0);
  endtask

  task automatic t_fill_full_overflow_drain();
    push(64, 8'h10, 1'b0);
    chk(pkt_cnt == 1, "R2", "64th byte completes", pkt_cnt, 1);
    chk(tx_svc && wr_ready, "R1", "service with one packet", tx_svc, 1);
    push(64, 8'h80, 1'b0);
    chk(pkt_cnt == 2, "R2", "second packet in other buffer", pkt_cnt, 2);
    chk(!tx_svc && !wr_ready, "R1", "service off with two", tx_svc, 0);
    push(1, 8'hEE, 1'b0);
    chk(ovf_err, "R4", "overflow flag after refused byte", ovf_err, 1);
    chk(pkt_cnt == 2, "R4", "count unchanged by refused byte", pkt_cnt, 2);
    strobe_short();
    chk(ovf_err && pkt_cnt == 2, "R4", "refused short strobe", ovf_err, 1);
    @(negedge clk);
    chk(!ovf_err, "R4", "overflow flag clears", ovf_err, 0);
    drain(64, 8'h10, 3, "R5");
    chk(pkt_cnt == 1 && tx_svc, "R6", "count drops after first packet", pkt_cnt, 1);
    drain(64, 8'h80, 0, "R6");
    chk(pkt_cnt == 0 && !rd_valid, "R6", "queue empty after drain", pkt_cnt, 0);
  endtask

  task automatic t_short_packets();
    push(5, 8'h30, 1'b1);
    chk(pkt_cnt == 1, "R3", "short strobe completes 5 bytes", pkt_cnt, 1);
    drain(5, 8'h30, 0, "R3");
    strobe_short();
    chk(pkt_cnt == 1, "R3", "zero-length packet counted", pkt_cnt, 1);
    drain(0, 0, 0, "R3");
    chk(pkt_cnt == 0, "R3", "zero-length packet released", pkt_cnt, 0);
    push(64, 8'h40, 1'b1);
    chk(pkt_cnt == 1, "R3", "short with 64th byte makes one packet", pkt_cnt, 1);
    drain(64, 8'h40, 0, "R3");
    chk(!rd_valid && pkt_cnt == 0, "R3", "no extra empty packet", rd_valid, 0);
  endtask

  task automatic t_interleave();
    push(64, 8'h55, 1'b0);
    push(10, 8'hA0, 1'b0);
    chk(pkt_cnt == 1, "R5", "partial buffer not counted", pkt_cnt, 1);
    drain(64, 8'h55, 0, "R6");
    chk(!rd_valid, "R5", "partial buffer not readable", rd_valid, 0);
    push(3, 8'hAA, 1'b1);
    drain(13, 8'hA0, 1, "R5");
  endtask

  task automatic t_flush();
    push(64, 8'h01, 1'b0);
    push(10, 8'h60, 1'b0);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    chk(pkt_cnt == 0 && tx_svc, "R7", "flush clears count", pkt_cnt, 0);
    chk(!rd_valid && wr_ready, "R7", "flush clears read side", rd_valid, 0);
    push(3, 8'hC0, 1'b1);
    drain(3, 8'hC0, 0, "R7");
  endtask

  initial begin
    #(8 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill_full_overflow_drain();
    t_short_packets();
    t_interleave();
    t_flush();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule